// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block sets how many bus-clock periods one processor bus cycle lasts, and steps that cycle through its clocks. A requester raises a strobe with the target area, an external chip-select index, the direction and the bus mode. The controller picks the cycle length from that request and from a set of configuration inputs. These are a register-area wait select, a global internal-wait bit, one no-wait bit per chip select and one 2-bit wait code per chip select.

While the cycle runs, the controller shows a busy flag and a phase count that starts at zero. It pulses done in the last clock of the cycle. External areas that run with wait states also honour a ready input, which stretches the last clock while it is low.

A configuration-error flag marks combinations that are not allowed: a reserved wait code, or a no-wait bit set where wait states are required. The error is reported with the cycle that used it. Area encoding is 2'b00 register area, 2'b01 internal memory, 2'b10 or 2'b11 external. Bus mode 0 is separate address/data and 1 is multiplexed. Direction 1 is a write.

Top module: `bus_wait_ctrl`

## Requirements
- R1: A register-area access (area 2'b00) lasts 3 clocks when the register wait select is 0 and 2 clocks when it is 1.
- R2: An internal-memory access (area 2'b01) lasts 1 clock when the internal-wait bit is 0 and 2 clocks when it is 1.
- R3: An external access on the separate bus uses the wait code of the selected chip select (bits [2i+1:2i] of the code vector) when its no-wait bit (bit i) and the internal-wait bit are 0. Codes 00, 01 and 10 give 2, 3 and 4 clocks. With the reset configuration (all zeros) every external access therefore takes 2 clocks.
- R4: An external access on the separate bus with the selected no-wait bit 1 and the internal-wait bit 0 lasts 1 clock for a read and 2 clocks for a write, whatever the wait code.
- R5: An external access on the multiplexed bus with the internal-wait bit 0 uses its wait code: 00 and 01 give 3 clocks and 10 gives 4 clocks.
- R6: With the internal-wait bit 1, every external access is a one-wait cycle: 2 clocks on the separate bus and 3 on the multiplexed bus, whatever the no-wait bit and the code.
- R7: Wait code 11, when the code sets the length, is timed as code 10 and raises the configuration-error flag.
- R8: The configuration-error flag is also raised when the selected no-wait bit is 1 on a multiplexed access or while the internal-wait bit is 1. The flag is high for all clocks of the offending cycle and is low outside it.
- R9: An external access timed with waits (every case except R4) stays in its last clock while ready is low, extending by whole clocks. Ready has no effect on register-area, internal or R4 no-wait accesses.
- R10: Done is high for exactly one clock, the last clock of the cycle. Phase is 0 in the first busy clock, steps by one per clock, and holds its final value during ready extension.
- R11: A request is taken only when idle or in a done clock, and busy rises in the next clock. Area, direction, mode, chip select and configuration are latched then, so later changes do not alter the running cycle. Back-to-back requests give cycles with no idle clock between them.
- R12: During and after reset, busy, done, phase and the error flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request strobe |
| area_i | input | 2 | Target area code |
| cs_i | input | CS_W | External chip-select index |
| wr_i | input | 1 | 1 for write, 0 for read |
| mux_i | input | 1 | 1 for multiplexed bus, 0 for separate bus |
| reg_fast_i | input | 1 | Register-area wait select |
| int_wait_i | input | 1 | Global internal-wait bit |
| nowait_i | input | NUM_CS | Per chip-select no-wait bits |
| wcode_i | input | 2*NUM_CS | Per chip-select 2-bit wait codes |
| rdy_i | input | 1 | External ready, active high |
| busy_o | output | 1 | Bus cycle in progress |
| phase_o | output | PH_W | Clock index within the cycle |
| done_o | output | 1 | Last clock of the cycle |
| cfg_err_o | output | 1 | Configuration error for the running cycle |

## Verification
Random requests cover every area, chip select, direction, bus mode and wait code, with random no-wait and internal-wait settings. They separate the same wait code on the two bus modes, reads from writes under no-wait, and legal settings from erroneous ones. Ready is held low for 0 to 3 extra clocks at the predicted last clock. This shows that honoured areas grow by exactly that many clocks and the others do not. All request and configuration inputs are scrambled while a cycle runs, to show that the length was latched. Directed cases cover the reset state, the all-zero configuration, code 11, and a chain of one-clock accesses with no idle gap.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    // Longest base cycle is 4 clocks, so its last index fits in 2 bits.
    localparam int LAST_W = 2;

    typedef enum logic [1:0] {
        AREA_REG  = 2'b00,
        AREA_INT  = 2'b01,
        AREA_EXT  = 2'b10,
        AREA_EXT2 = 2'b11
    } area_e;

    // Timing of one cycle as decided at request time.
    typedef struct packed {
        logic [LAST_W-1:0] last;    // index of the final clock (length - 1)
        logic              rdy_en;  // ready input honoured
        logic              err;     // configuration error
    } cyc_cfg_t;

endpackage

// File: rtl/bwc_area_sel.sv
module bwc_area_sel #(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic [CS_W-1:0]     cs_i,
    input  logic [NUM_CS-1:0]   nowait_vec_i,
    input  logic [2*NUM_CS-1:0] wcode_vec_i,
    output logic                nowait_o,
    output logic [1:0]          wcode_o
);

    logic [NUM_CS-1:0] hit;
    logic [1:0]        code_arr [NUM_CS];

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign hit[gi]      = (cs_i == CS_W'(gi));
        assign code_arr[gi] = wcode_vec_i[2*gi +: 2];
    end

    always_comb begin
        nowait_o = 1'b0;
        wcode_o  = 2'b00;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit[i]) begin
                nowait_o = nowait_vec_i[i];
                wcode_o  = code_arr[i];
            end
        end
    end

endmodule

// File: rtl/bwc_len_calc.sv
module bwc_len_calc
    import bwc_pkg::*;
(
    input  area_e     area_i,
    input  logic      wr_i,
    input  logic      mux_i,
    input  logic      reg_fast_i,
    input  logic      int_wait_i,
    input  logic      nowait_i,
    input  logic [1:0] wcode_i,
    output cyc_cfg_t  cfg_o
);

    logic [1:0] code_eff;
    logic       nw_eff;
    logic       code_rsvd;

    always_comb begin
        code_rsvd = (wcode_i == 2'b11);
        code_eff  = code_rsvd ? 2'b10 : wcode_i;
        // no-wait only takes effect on the separate bus without global wait
        nw_eff    = nowait_i & ~mux_i & ~int_wait_i;

        cfg_o = '0;
        unique case (area_i)
            AREA_REG: begin
                cfg_o.last = reg_fast_i ? LAST_W'(1) : LAST_W'(2);
            end
            AREA_INT: begin
                cfg_o.last = int_wait_i ? LAST_W'(1) : LAST_W'(0);
            end
            default: begin
                if (int_wait_i) begin
                    cfg_o.last = mux_i ? LAST_W'(2) : LAST_W'(1);
                end else if (nw_eff) begin
                    cfg_o.last = wr_i ? LAST_W'(1) : LAST_W'(0);
                end else if (mux_i) begin
                    cfg_o.last = (code_eff == 2'b10) ? LAST_W'(3) : LAST_W'(2);
                end else begin
                    cfg_o.last = code_eff + LAST_W'(1);
                end
                cfg_o.rdy_en = ~nw_eff;
                cfg_o.err    = (nowait_i & (mux_i | int_wait_i))
                             | (~int_wait_i & ~nw_eff & code_rsvd);
            end
        endcase
    end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
    import bwc_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  cyc_cfg_t        cfg_i,
    input  logic            rdy_i,
    output logic            busy_o,
    output logic [PH_W-1:0] phase_o,
    output logic            done_o,
    output logic            err_o
);

    typedef struct packed {
        logic              busy;
        logic [PH_W-1:0]   phase;
        logic [LAST_W-1:0] last;
        logic              rdy_en;
        logic              err;
    } st_t;

    st_t  st_d, st_q;
    logic at_last;
    logic done;
    logic accept;

    always_comb begin
        at_last = (st_q.phase == PH_W'(st_q.last));
        done    = st_q.busy & at_last & (~st_q.rdy_en | rdy_i);
        accept  = req_i & (~st_q.busy | done);

        st_d = st_q;
        if (st_q.busy && !at_last) begin
            st_d.phase = st_q.phase + PH_W'(1);
        end
        if (done) begin
            st_d.busy  = 1'b0;
            st_d.phase = '0;
            st_d.err   = 1'b0;
        end
        if (accept) begin
            st_d.busy   = 1'b1;
            st_d.phase  = '0;
            st_d.last   = cfg_i.last;
            st_d.rdy_en = cfg_i.rdy_en;
            st_d.err    = cfg_i.err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign phase_o = st_q.phase;
    assign done_o  = done;
    assign err_o   = st_q.err;

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    parameter int PH_W   = LAST_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [1:0]          area_i,
    input  logic [CS_W-1:0]     cs_i,
    input  logic                wr_i,
    input  logic                mux_i,
    input  logic                reg_fast_i,
    input  logic                int_wait_i,
    input  logic [NUM_CS-1:0]   nowait_i,
    input  logic [2*NUM_CS-1:0] wcode_i,
    input  logic                rdy_i,
    output logic                busy_o,
    output logic [PH_W-1:0]     phase_o,
    output logic                done_o,
    output logic                cfg_err_o
);

    logic       sel_nowait;
    logic [1:0] sel_code;
    cyc_cfg_t   cyc_cfg;

    bwc_area_sel #(
        .NUM_CS (NUM_CS),
        .CS_W   (CS_W)
    ) u_sel (
        .cs_i         (cs_i),
        .nowait_vec_i (nowait_i),
        .wcode_vec_i  (wcode_i),
        .nowait_o     (sel_nowait),
        .wcode_o      (sel_code)
    );

    bwc_len_calc u_len (
        .area_i     (area_e'(area_i)),
        .wr_i       (wr_i),
        .mux_i      (mux_i),
        .reg_fast_i (reg_fast_i),
        .int_wait_i (int_wait_i),
        .nowait_i   (sel_nowait),
        .wcode_i    (sel_code),
        .cfg_o      (cyc_cfg)
    );

    bwc_seq #(
        .PH_W (PH_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .cfg_i   (cyc_cfg),
        .rdy_i   (rdy_i),
        .busy_o  (busy_o),
        .phase_o (phase_o),
        .done_o  (done_o),
        .err_o   (cfg_err_o)
    );

endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
    parameter int PH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic            busy_o,
    input logic [PH_W-1:0] phase_o,
    input logic            done_o,
    input logic            cfg_err_o
);

    // R10: done only inside a running cycle
    a_r10_done_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R12 / R8: idle outputs quiet
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (phase_o == '0 && !cfg_err_o));

    // R10: a cycle cannot end without done
    a_r10_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R10: phase steps by one or holds during extension
    a_r10_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=>
            (phase_o == $past(phase_o) || phase_o == PH_W'($past(phase_o) + 1'b1)));

    // R11: request while idle starts a cycle at phase 0
    a_r11_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> (busy_o && phase_o == '0));

    // R11: done without a new request returns to idle
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !req_i) |=> !busy_o);

    // R8: error flag constant within a cycle
    a_r8_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(cfg_err_o));

endmodule

bind bus_wait_ctrl bwc_checker #(.PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .busy_o    (busy_o),
    .phase_o   (phase_o),
    .done_o    (done_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/tb_bus_wait_ctrl.sv
`timescale 1ns/1ps
module tb_bus_wait_ctrl;

    localparam int NUM_CS = 4;
    localparam int CS_W   = 2;
    localparam int PH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic [1:0]        area_i = '0;
    logic [CS_W-1:0]   cs_i = '0;
    logic              wr_i = 1'b0;
    logic              mux_i = 1'b0;
    logic              reg_fast_i = 1'b0;
    logic              int_wait_i = 1'b0;
    logic [NUM_CS-1:0] nowait_i = '0;
    logic [2*NUM_CS-1:0] wcode_i = '0;
    logic              rdy_i = 1'b1;
    logic              busy_o;
    logic [PH_W-1:0]   phase_o;
    logic              done_o;
    logic              cfg_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    bus_wait_ctrl #(.NUM_CS(NUM_CS)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .area_i(area_i), .cs_i(cs_i),
        .wr_i(wr_i), .mux_i(mux_i), .reg_fast_i(reg_fast_i), .int_wait_i(int_wait_i),
        .nowait_i(nowait_i), .wcode_i(wcode_i), .rdy_i(rdy_i),
        .busy_o(busy_o), .phase_o(phase_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns {len[2:0], rdy_en, err}
    function automatic logic [4:0] model(input logic [1:0] area, input logic wr,
                                         input logic mux, input logic rf, input logic iw,
                                         input logic nw, input logic [1:0] code);
        int len; logic re; logic er; int ec;
        re = 0; er = 0;
        ec = (code == 2'b11) ? 2 : int'(code);
        if (area == 2'b00) len = rf ? 2 : 3;
        else if (area == 2'b01) len = iw ? 2 : 1;
        else if (iw) begin
            len = mux ? 3 : 2; re = 1; er = nw;
        end else if (nw && !mux) begin
            len = wr ? 2 : 1;
        end else begin
            len = mux ? ((ec == 2) ? 4 : 3) : ec + 2;
            re = 1; er = nw | (code == 2'b11);
        end
        return {3'(len), re, er};
    endfunction

    function automatic string tag_of(input logic [1:0] area, input logic mux,
                                     input logic iw, input logic nw, input logic [1:0] code);
        if (area == 2'b00) return "R1";
        if (area == 2'b01) return "R2";
        if (iw) return "R6";
        if (code == 2'b11) return "R7";
        if (nw) return mux ? "R8" : "R4";
        return mux ? "R5" : "R3";
    endfunction

    task automatic scramble();
        area_i = 2'($urandom); cs_i = CS_W'($urandom); wr_i = 1'($urandom);
        mux_i = 1'($urandom); reg_fast_i = 1'($urandom); int_wait_i = 1'($urandom);
        nowait_i = NUM_CS'($urandom); wcode_i = (2*NUM_CS)'($urandom);
    endtask

    task automatic run(input logic [1:0] area, input logic [CS_W-1:0] cs, input logic wr,
                       input logic mux, input logic rf, input logic iw,
                       input logic [NUM_CS-1:0] nwv, input logic [2*NUM_CS-1:0] wcv,
                       input int stall);
        logic [4:0] m; int len; int tot; string tg; bit seen;
        m   = model(area, wr, mux, rf, iw, nwv[cs], wcv[2*cs +: 2]);
        len = int'(m[4:2]);
        tot = m[1] ? len + stall : len;
        tg  = tag_of(area, mux, iw, nwv[cs], wcv[2*cs +: 2]);
        @(negedge clk);
        req_i = 1'b1; area_i = area; cs_i = cs; wr_i = wr; mux_i = mux;
        reg_fast_i = rf; int_wait_i = iw; nowait_i = nwv; wcode_i = wcv;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        seen = 0;
        for (int k = 1; k <= 12 && !seen; k++) begin
            if (k > 1) @(negedge clk);
            scramble();  // R11: changes after acceptance must not matter
            if (k < len) rdy_i = 1'($urandom);
            else if (k < len + stall) rdy_i = 1'b0;
            else rdy_i = 1'b1;
            #1;
            check(busy_o == 1'b1, "R11 busy", int'(busy_o), 1);
            check(int'(phase_o) == ((k - 1 < len - 1) ? k - 1 : len - 1),
                  "R10 phase", int'(phase_o), (k - 1 < len - 1) ? k - 1 : len - 1);
            check(cfg_err_o == m[0], (m[0] ? "R8 err" : "R8 noerr"), int'(cfg_err_o), int'(m[0]));
            if (done_o) begin
                seen = 1;
                check(k == tot, (stall > 0) ? "R9 length" : tg, k, tot);
            end
        end
        if (!seen) check(0, tg, 99, tot);
        @(negedge clk);
        rdy_i = 1'b1;
        #1;
        check(busy_o == 1'b0 && done_o == 1'b0, "R10 single done", int'(busy_o), 0);
    endtask

    initial begin
        #(5.0 * 200000);
        check(0, "watchdog", 0, 1);
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        #1;
        check(busy_o == 0 && done_o == 0 && phase_o == 0 && cfg_err_o == 0,
              "R12 in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(busy_o == 0 && done_o == 0 && phase_o == 0 && cfg_err_o == 0,
              "R12 after reset", int'(busy_o), 0);

        // directed corners
        run(2'b00, 0, 0, 0, 0, 0, '0, '0, 2);          // R1 slow, ready ignored (R9)
        run(2'b00, 0, 1, 0, 1, 0, '0, '0, 0);          // R1 fast
        run(2'b01, 0, 0, 0, 0, 0, '0, '0, 3);          // R2 no wait, ready ignored
        run(2'b01, 0, 1, 0, 0, 1, '0, '0, 0);          // R2 wait
        run(2'b10, 2, 0, 0, 0, 0, '0, '0, 0);          // R3 reset config: 2 clocks
        run(2'b10, 1, 0, 0, 0, 0, '0, 8'b0000_1000, 0); // R3 code 10 -> 4
        run(2'b10, 3, 0, 0, 0, 0, 4'b1000, '0, 2);     // R4 read, ready ignored
        run(2'b10, 3, 1, 0, 0, 0, 4'b1000, '0, 0);     // R4 write
        run(2'b10, 0, 0, 1, 0, 0, '0, 8'b0000_0001, 0); // R5 code 01 -> 3
        run(2'b11, 0, 0, 1, 0, 0, '0, 8'b0000_0010, 1); // R5 code 10 -> 4, R9 stall
        run(2'b10, 1, 0, 0, 0, 1, 4'b0010, 8'b0000_1100, 0); // R6 with error
        run(2'b10, 2, 0, 0, 0, 0, '0, 8'b0011_0000, 0); // R7 sep code 11
        run(2'b10, 2, 0, 1, 0, 0, '0, 8'b0011_0000, 0); // R7 mux code 11
        run(2'b10, 0, 0, 1, 0, 0, 4'b0001, '0, 0);     // R8 no-wait on mux

        // R11: back-to-back one-clock internal accesses, no idle gap
        @(negedge clk);
        req_i = 1'b1; area_i = 2'b01; int_wait_i = 1'b0;
        @(posedge clk);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk); #1;
            check(busy_o && done_o && phase_o == 0, "R11 back-to-back", int'(done_o), 1);
        end
        req_i = 1'b0;
        @(negedge clk); #1;
        check(busy_o == 0, "R11 chain end", int'(busy_o), 0);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            run(2'($urandom), CS_W'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom % 4) == 0, NUM_CS'($urandom),
                (2*NUM_CS)'($urandom), int'($urandom % 4));
        end

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule